// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Generator

This block produces test stimulus for built-in self test from an ordinary accumulator. A pattern register (A) feeds the inputs of the logic under test, and an addend register (B) is added to it on every clock. Each pattern bit carries one of three weights within a test session. Weight 1 pins the bit high. Weight 0 pins it low. Weight one-half leaves the bit free, so it takes the running sum and looks pseudorandom.

Pinning works through complementary set and clear controls on the two registers. A bit pinned high gets A=1 and B=0. A bit pinned low gets A=0 and B=1. In both cases the sum of the two operand bits is one, so that stage hands its carry-in straight to its carry-out. The free bits above a pinned bit therefore keep counting as if the pinned bit were not there, and the adder needs no change.

A control state machine walks a parameter-programmed list of sessions. For each session it holds a set vector, a clear vector and an addend for the free bits, and it emits a fixed number of patterns per session. It has three states:
- `ST_IDLE`, after reset.
- `ST_RUN`, while patterns are produced.
- `ST_DONE`, after the last session.

It has four transitions:
- GO: from `ST_IDLE` to `ST_RUN`, taken on start.
- NEXT_SESSION: from `ST_RUN` back to `ST_RUN`, taken on the last pattern of a session that is not the final one.
- FINISH: from `ST_RUN` to `ST_DONE`, taken on the last pattern of the final session.
- RESTART: from `ST_DONE` to `ST_RUN`, taken on start.

Top module: `tw_pattern_gen`

## Requirements
- R1: While reset is asserted, and until the first start, pattern is 0, session is 0 and done is 0.
- R2: A start seen in `ST_IDLE` or `ST_DONE` at a clock edge loads session 0. From that edge, pattern shows that session's first pattern: pinned bits at their values and free bits 0.
- R3: Bit i of session s is pinned high when SESS_SET[s*WIDTH+i] is 1. Such a bit reads 1 for every pattern of that session.
- R4: Bit i of session s is pinned low when SESS_CLR[s*WIDTH+i] is 1. Such a bit reads 0 for every pattern of that session. A bit never has both its set and its clear enabled.
- R5: Each following pattern is (A+B) mod 2^WIDTH, with the pinned bits then re-forced. B holds the complement of A on pinned bits and SESS_ADD on free bits. The free bits therefore step, taken together as one number, by the free bits of SESS_ADD, with carries crossing pinned positions unchanged.
- R6: Each session lasts PATS clock cycles. The session output gives the index of the session whose patterns are shown, and sessions run in order 0 to NUM_SESS-1.
- R7: One cycle after the last pattern of the last session, done goes to 1. Done stays 1, and the pattern holds, until the next start.
- R8: Start has no effect while patterns are being produced.
- R9: With the default configuration, every free bit of a session takes both values 0 and 1 within that session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the session list when idle or finished |
| pattern | output | WIDTH | Register A contents, the stimulus to the logic under test |
| session | output | SESS_W | Index of the session now being applied |
| done | output | 1 | All sessions complete |

## Verification
The sequence is compared, pattern by pattern, against a model that packs the free bits into one counter and steps it by the packed addend. That check separates a correct carry crossing at a pinned stage from a carry lost or doubled there. The two sessions differ in pinning: one has only high pins, the other has a high pin between two low pins. This tells set-driven forcing apart from clear-driven forcing. Start pulses dropped at random cycles inside a run, random idle gaps, and restarts from the finished state show that start only acts when no run is in progress, and that each run begins again from the first pattern.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tw_state_e;
endpackage

// File: rtl/tw_ripple_add.sv
module tw_ripple_add #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic p, g;
        assign p      = a[i] ^ b[i];
        assign g      = a[i] & b[i];
        assign sum[i] = p ^ c[i];
        // generate and propagate-with-carry never hold together, so XOR merges them
        assign c[i+1] = g ^ (p & c[i]);
    end
endmodule

// File: rtl/tw_decode.sv
module tw_decode #(
    parameter int WIDTH    = 5,
    parameter int NUM_SESS = 2,
    parameter int SESS_W   = 1,
    parameter logic [NUM_SESS*WIDTH-1:0] SESS_SET = '0,
    parameter logic [NUM_SESS*WIDTH-1:0] SESS_CLR = '0,
    parameter logic [NUM_SESS*WIDTH-1:0] SESS_ADD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SESS_W-1:0] idx,
    output logic [WIDTH-1:0]  set_v,
    output logic [WIDTH-1:0]  clr_v,
    output logic [WIDTH-1:0]  add_v
);
    logic [WIDTH-1:0] set_tab [NUM_SESS];
    logic [WIDTH-1:0] clr_tab [NUM_SESS];
    logic [WIDTH-1:0] add_tab [NUM_SESS];

    for (genvar s = 0; s < NUM_SESS; s++) begin : g_sess
        assign set_tab[s] = SESS_SET[s*WIDTH +: WIDTH];
        assign clr_tab[s] = SESS_CLR[s*WIDTH +: WIDTH];
        assign add_tab[s] = SESS_ADD[s*WIDTH +: WIDTH];
    end

    always_comb begin
        set_v = '0;
        clr_v = '0;
        add_v = '0;
        for (int s = 0; s < NUM_SESS; s++) begin
            if (idx == SESS_W'(s)) begin
                set_v = set_tab[s];
                clr_v = clr_tab[s];
                add_v = add_tab[s];
            end
        end
    end

    // R4: a bit is never both set and cleared
    a_r4_set_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v & clr_v) == '0);
endmodule

// File: rtl/tw_regs.sv
module tw_regs #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] set_v,
    input  logic [WIDTH-1:0] clr_v,
    input  logic [WIDTH-1:0] add_v,
    input  logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q
);
    logic [WIDTH-1:0] pin_m;
    assign pin_m = set_v | clr_v;

    // set drives A high and B low; clear drives A low and B high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= set_v;
            b_q <= clr_v | (add_v & ~pin_m);
        end else if (step) begin
            a_q <= (sum & ~clr_v) | set_v;
        end
    end

    // R5: pinned stages hold complementary operands so carry passes through
    a_r5_pinned_complement: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ((a_q ^ b_q) & pin_m) == pin_m);
    a_r3_forced_one: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (a_q & $past(set_v)) == $past(set_v));
    a_r4_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (a_q & $past(clr_v)) == '0);
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int NUM_SESS = 2,
    parameter int PATS     = 12,
    parameter int SESS_W   = 1,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              load,
    output logic              step,
    output logic [SESS_W-1:0] sess,
    output logic [SESS_W-1:0] cfg_idx,
    output logic              done
);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PATS - 1);
    localparam logic [SESS_W-1:0] SESS_LAST = SESS_W'(NUM_SESS - 1);

    tw_state_e         st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [SESS_W-1:0] sess_n;

    always_comb begin
        st_n   = st;
        sess_n = sess;
        cnt_n  = cnt;
        load   = 1'b0;
        step   = 1'b0;
        unique case (st)
            ST_IDLE, ST_DONE: begin
                if (start) begin           // GO / RESTART
                    st_n   = ST_RUN;
                    sess_n = '0;
                    cnt_n  = '0;
                    load   = 1'b1;
                end
            end
            ST_RUN: begin
                if (cnt == CNT_LAST) begin
                    if (sess == SESS_LAST) begin
                        st_n = ST_DONE;    // FINISH
                    end else begin         // NEXT_SESSION
                        sess_n = sess + 1'b1;
                        cnt_n  = '0;
                        load   = 1'b1;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                    step  = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign cfg_idx = sess_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            sess <= '0;
            cnt  <= '0;
        end else begin
            st   <= st_n;
            sess <= sess_n;
            cnt  <= cnt_n;
        end
    end

    always_comb begin
        done = (st == ST_DONE);
    end

    a_r6_session_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && cnt != CNT_LAST) |=> $stable(sess));
    a_r7_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sess == SESS_LAST);
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && cnt != CNT_LAST && start) |=> (st == ST_RUN && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tw_pattern_gen.sv
module tw_pattern_gen #(
    parameter int WIDTH    = 5,
    parameter int NUM_SESS = 2,
    parameter int PATS     = 12,
    parameter logic [NUM_SESS*WIDTH-1:0] SESS_SET = {5'b00010, 5'b00101},
    parameter logic [NUM_SESS*WIDTH-1:0] SESS_CLR = {5'b00101, 5'b00000},
    parameter logic [NUM_SESS*WIDTH-1:0] SESS_ADD = {5'b01000, 5'b01010},
    localparam int SESS_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1,
    localparam int CNT_W  = (PATS > 1) ? $clog2(PATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [WIDTH-1:0]  pattern,
    output logic [SESS_W-1:0] session,
    output logic              done
);
    logic              load, step;
    logic [SESS_W-1:0] cfg_idx;
    logic [WIDTH-1:0]  set_v, clr_v, add_v, sum, a_q, b_q;

    tw_ctrl #(.NUM_SESS(NUM_SESS), .PATS(PATS), .SESS_W(SESS_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load), .step(step),
        .sess(session), .cfg_idx(cfg_idx), .done(done)
    );

    tw_decode #(.WIDTH(WIDTH), .NUM_SESS(NUM_SESS), .SESS_W(SESS_W),
                .SESS_SET(SESS_SET), .SESS_CLR(SESS_CLR), .SESS_ADD(SESS_ADD)) u_dec (
        .clk(clk), .rst_n(rst_n), .idx(cfg_idx),
        .set_v(set_v), .clr_v(clr_v), .add_v(add_v)
    );

    tw_ripple_add #(.WIDTH(WIDTH)) u_add (.a(a_q), .b(b_q), .sum(sum));

    tw_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .set_v(set_v), .clr_v(clr_v), .add_v(add_v), .sum(sum),
        .a_q(a_q), .b_q(b_q)
    );

    assign pattern = a_q;

    a_r7_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(pattern) && done));
endmodule

// File: tb/tw_pattern_gen_test.sv
module tw_pattern_gen_test;
    localparam int W  = 5;
    localparam int NS = 2;
    localparam int P  = 12;
    localparam logic [W-1:0] SET0 = 5'b00101, CLR0 = 5'b00000, ADD0 = 5'b01010;
    localparam logic [W-1:0] SET1 = 5'b00010, CLR1 = 5'b00101, ADD1 = 5'b01000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] pattern;
    logic [0:0] session;
    logic done;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tw_pattern_gen #(.WIDTH(W), .NUM_SESS(NS), .PATS(P),
        .SESS_SET({SET1, SET0}), .SESS_CLR({CLR1, CLR0}), .SESS_ADD({ADD1, ADD0})) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pattern(pattern), .session(session), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // packed free-bit counter model
    function automatic logic [W-1:0] ref_pat(input int s, input int j);
        logic [W-1:0] st, cl, ad, fr, r;
        int k, addc, val;
        st = (s == 0) ? SET0 : SET1;
        cl = (s == 0) ? CLR0 : CLR1;
        ad = (s == 0) ? ADD0 : ADD1;
        fr = ~(st | cl);
        addc = 0; k = 0;
        for (int i = 0; i < W; i++) if (fr[i]) begin
            if (ad[i]) addc += (1 << k);
            k++;
        end
        val = (j * addc) % (1 << k);
        r = st; k = 0;
        for (int i = 0; i < W; i++) if (fr[i]) begin
            r[i] = ((val >> k) & 1) != 0;
            k++;
        end
        return r;
    endfunction

    task automatic run_all(input bit noisy);
        @(negedge clk) start = 1'b1;
        for (int s = 0; s < NS; s++) begin
            logic [W-1:0] seen0 = '0, seen1 = '0, fr;
            fr = ~((s == 0 ? SET0 : SET1) | (s == 0 ? CLR0 : CLR1));
            for (int j = 0; j < P; j++) begin
                @(negedge clk);
                start = 1'b0;
                if (s == 0 && j == 0)
                    check(pattern == ref_pat(0, 0), "R2", pattern, ref_pat(0, 0));
                check(pattern == ref_pat(s, j), "R5", pattern, ref_pat(s, j));
                check((pattern & (s == 0 ? SET0 : SET1)) == (s == 0 ? SET0 : SET1), "R3", pattern, s);
                check((pattern & (s == 0 ? CLR0 : CLR1)) == 0, "R4", pattern, s);
                check(session == s[0] && !done, "R6", {session, done}, s * 2);
                seen0 |= ~pattern; seen1 |= pattern;
                if (noisy && ($urandom % 3 == 0)) start = 1'b1;   // R8: must be ignored
            end
            check((seen0 & seen1 & fr) == fr, "R9", seen0 & seen1, fr);
        end
        @(negedge clk) start = 1'b0;
        check(done == 1'b1, "R7", done, 1);
        for (int h = 0; h < 3 + ($urandom % 5); h++) begin
            @(negedge clk);
            check(done && pattern == ref_pat(NS - 1, P - 1), "R7", pattern, ref_pat(NS - 1, P - 1));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(pattern == 0 && session == 0 && done == 0, "R1", {pattern, session, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pattern == 0 && session == 0 && done == 0, "R1", {pattern, session, done}, 0);
        run_all(1'b0);
        run_all(1'b1);
        for (int r = 0; r < 4; r++) begin
            repeat ($urandom % 6) @(negedge clk);
            run_all(1'b1);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule